// File: doc/BRIEF.md
# Register Load-Immediate Instruction Decoder

This block watches a stream of instruction bytes, one per cycle, and decodes the family of instructions that load a constant straight into a general register. The destination register is held in the low three bits of the opcode. The immediate follows in little-endian byte order. Before the opcode there may be an operand-size override byte (0x66) and, in 64-bit mode, a register-extension byte (0x40 to 0x4F). These prefixes change the operand width and how the register code is read. Any other byte in the opcode position, or a prefix that breaks the ordering rules, ends the decode with an error pulse.

When the last immediate byte has been taken, the block shows one result for a single cycle. The result holds the register number (0 to 15), the operand width, a flag for the legacy high-byte registers, the immediate zero-extended to 64 bits, and the instruction length in bytes. Bytes arrive under a valid/ready handshake. The block drops ready for one cycle while it shows a result or an error, and then goes back to waiting for the first byte of the next instruction. The `mode64` input picks 64-bit operation (high) or 32-bit operation (low). It must stay stable during an instruction.

Top module: `movimm_decoder`

## Requirements
- R1: Opcodes 0xB0 to 0xB7 decode as an 8-bit load (out_width = 2'b00) with register code opcode[2:0] and exactly one immediate byte.
- R2: With no prefix, opcodes 0xB8 to 0xBF decode as a 32-bit load (out_width = 2'b10) with register code opcode[2:0] and four immediate bytes.
- R3: A 0x66 byte before 0xB8 to 0xBF selects a 16-bit load (out_width = 2'b01) with two immediate bytes.
- R4: In 64-bit mode, a byte 0x40 to 0x4F placed directly before the opcode is taken as the extension prefix. If its bit 3 (W) is set and the opcode is 0xB8 to 0xBF, the load is 64-bit (out_width = 2'b11) with eight immediate bytes, even when 0x66 also came first.
- R5: With no extension prefix, an 8-bit load with register code 4 to 7 sets out_hibyte. In every other case out_hibyte is low.
- R6: When any extension prefix is present, bit 0 of that prefix becomes out_reg[3], and out_hibyte stays low even for 8-bit codes 4 to 7.
- R7: In 32-bit mode, bytes 0x40 to 0x4F are not prefixes. In the opcode position they raise the error pulse.
- R8: Immediate bytes are assembled least significant first. out_imm is zero above the operand width.
- R9: out_len equals the number of prefix bytes, plus one for the opcode, plus the number of immediate bytes.
- R10: out_valid and err each last exactly one cycle. in_ready is low in that cycle and high again in the next cycle.
- R11: An error pulse follows any of these: an opcode byte outside 0xB0 to 0xBF, a second 0x66, a second extension prefix, or a 0x66 after an extension prefix. After the pulse, decoding restarts cleanly.
- R12: After reset, out_valid and err are low and in_ready is high.
- R13: Cycles with in_valid low between bytes do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| in_valid | input | 1 | in_byte holds a byte |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_reg | output | 4 | Destination register number |
| out_width | output | 2 | 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| out_hibyte | output | 1 | Destination is a legacy high-byte register |
| out_imm | output | 64 | Zero-extended immediate |
| out_len | output | 4 | Instruction length in bytes |
| err | output | 1 | One-cycle decode error strobe |

## Verification
The directed tests target the prefix interactions most likely to break:
- **W over 0x66.** A decoder that lets 0x66 win over W would report 16 bits and a length of 5 instead of 11.
- **8-bit codes 4 to 7 after a REX byte with W clear.** A decoder that forgets to reread the code would raise the high-byte flag.
- **32-bit mode.** Here 0x40 to 0x4F must be rejected rather than absorbed as a prefix.

Ordering faults get their own cases: duplicate prefixes and 0x66 after the extension byte must each produce one error and then a clean restart. Tests with idle cycles between bytes check that gaps neither advance the immediate lane nor count toward the length.

// File: rtl/movimm_pkg.sv
// Shared types and constants for the load-immediate decoder.
// Assumes byte-wide input and immediates of at most 64 bits.
package movimm_pkg;

    typedef enum logic [1:0] {
        W8  = 2'b00,
        W16 = 2'b01,
        W32 = 2'b10,
        W64 = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        ST_PFX  = 2'b00,
        ST_IMM  = 2'b01,
        ST_DONE = 2'b10,
        ST_ERR  = 2'b11
    } state_e;

    localparam logic [7:0] OPSZ_BYTE = 8'h66;
    localparam logic [3:0] REX_HI    = 4'h4;
    localparam logic [4:0] OPC_HI    = 5'b10110;

    // Number of immediate bytes that follow the opcode for a width
    function automatic logic [3:0] imm_count(input width_e w);
        case (w)
            W8:      imm_count = 4'd1;
            W16:     imm_count = 4'd2;
            W32:     imm_count = 4'd4;
            default: imm_count = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/movimm_prefix_tracker.sv
// Tracks the operand-size and register-extension prefixes of one instruction.
// Assumes the extension prefix may only be the byte directly before the opcode,
// so a size prefix arriving after it is treated as a conflict.
module movimm_prefix_tracker
    import movimm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       accept,
    input  logic       mode64,
    input  logic [7:0] byte_in,
    output logic       is_prefix,
    output logic       conflict,
    output logic       saw_opsz,
    output logic       saw_rex,
    output logic [3:0] rex_bits
);

    logic is_opsz;
    logic is_rex;

    // Classify the current byte as a prefix and check ordering rules
    always_comb begin
        is_opsz   = (byte_in == OPSZ_BYTE);
        is_rex    = mode64 && (byte_in[7:4] == REX_HI);
        is_prefix = is_opsz || is_rex;
        conflict  = (is_opsz && (saw_opsz || saw_rex)) || (is_rex && saw_rex);
    end

    // Record accepted prefixes until the instruction finishes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            saw_opsz <= 1'b0;
            saw_rex  <= 1'b0;
            rex_bits <= 4'h0;
        end else if (accept && is_prefix && !conflict) begin
            if (is_opsz) begin
                saw_opsz <= 1'b1;
            end
            if (is_rex) begin
                saw_rex  <= 1'b1;
                rex_bits <= byte_in[3:0];
            end
        end
    end

endmodule

// File: rtl/movimm_opcode_classify.sv
// Pure combinational decode of an opcode byte against the prefix state.
// Assumes the caller only consults it for a byte that is not a prefix.
module movimm_opcode_classify
    import movimm_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       saw_opsz,
    input  logic       saw_rex,
    input  logic [3:0] rex_bits,
    output logic       legal,
    output width_e     width,
    output logic [3:0] reg_num,
    output logic       hibyte,
    output logic [3:0] nbytes
);

    logic wide_form;

    // Derive width, register number and high-byte flag from opcode and prefixes
    always_comb begin
        legal     = (opcode[7:4] == OPC_HI[4:1]) && opcode[3] == 1'b0
                    ? 1'b1 : (opcode[7:3] == 5'b10111);
        wide_form = opcode[3];
        if (!wide_form) begin
            width = W8;
        end else if (saw_rex && rex_bits[3]) begin
            width = W64;
        end else if (saw_opsz) begin
            width = W16;
        end else begin
            width = W32;
        end
        reg_num = {saw_rex & rex_bits[0], opcode[2:0]};
        hibyte  = !wide_form && !saw_rex && opcode[2];
        nbytes  = imm_count(width);
    end

endmodule

// File: rtl/movimm_imm_assembler.sv
// Collects immediate bytes least significant first into a zero-filled word.
// Assumes start and accept are never high in the same cycle.
module movimm_imm_assembler #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              accept,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] value,
    output logic [$clog2(DATA_W/8)-1:0] idx
);

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    // Advance the lane pointer on each accepted immediate byte
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            idx <= '0;
        end else if (accept) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // One register per byte lane, written when the pointer selects it
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                value[g*8 +: 8] <= 8'h00;
            end else if (accept && idx == IDX_W'(g)) begin
                value[g*8 +: 8] <= byte_in;
            end
        end
    end

endmodule

// File: rtl/movimm_decoder.sv
// Top level: sequences prefix, opcode and immediate bytes of a
// register-load-immediate instruction and presents a one-cycle result.
// Assumes mode64 is stable for the duration of each instruction.
module movimm_decoder
    import movimm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [3:0]        out_reg,
    output logic [1:0]        out_width,
    output logic              out_hibyte,
    output logic [DATA_W-1:0] out_imm,
    output logic [LEN_W-1:0]  out_len,
    output logic              err
);

    localparam int IDX_W = $clog2(DATA_W / 8);

    state_e             state_q;
    state_e             state_d;
    logic               accept;
    logic               clear;
    logic               is_prefix;
    logic               conflict;
    logic               saw_opsz;
    logic               saw_rex;
    logic [3:0]         rex_bits;
    logic               legal;
    width_e             cls_width;
    logic [3:0]         cls_reg;
    logic               cls_hibyte;
    logic [3:0]         cls_nbytes;
    logic               opc_take;
    logic               imm_take;
    logic               last_imm;
    logic [IDX_W-1:0]   imm_idx;
    width_e             width_q;
    logic [3:0]         reg_q;
    logic               hibyte_q;
    logic [3:0]         need_q;
    logic [LEN_W-1:0]   len_q;

    // Handshake and control strobes derived from the current state
    always_comb begin
        in_ready = (state_q == ST_PFX) || (state_q == ST_IMM);
        accept   = in_valid && in_ready;
        clear    = (state_q == ST_DONE) || (state_q == ST_ERR);
        opc_take = accept && (state_q == ST_PFX) && !is_prefix && legal;
        imm_take = accept && (state_q == ST_IMM);
        last_imm = imm_take && ({1'b0, imm_idx} == need_q - 4'd1);
    end

    movimm_prefix_tracker u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .accept    (accept && (state_q == ST_PFX)),
        .mode64    (mode64),
        .byte_in   (in_byte),
        .is_prefix (is_prefix),
        .conflict  (conflict),
        .saw_opsz  (saw_opsz),
        .saw_rex   (saw_rex),
        .rex_bits  (rex_bits)
    );

    movimm_opcode_classify u_cls (
        .opcode   (in_byte),
        .saw_opsz (saw_opsz),
        .saw_rex  (saw_rex),
        .rex_bits (rex_bits),
        .legal    (legal),
        .width    (cls_width),
        .reg_num  (cls_reg),
        .hibyte   (cls_hibyte),
        .nbytes   (cls_nbytes)
    );

    movimm_imm_assembler #(.DATA_W(DATA_W)) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (opc_take),
        .accept  (imm_take),
        .byte_in (in_byte),
        .value   (out_imm),
        .idx     (imm_idx)
    );

    // Next-state selection for the byte sequencer
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PFX: begin
                if (accept) begin
                    if (is_prefix) begin
                        state_d = conflict ? ST_ERR : ST_PFX;
                    end else begin
                        state_d = legal ? ST_IMM : ST_ERR;
                    end
                end
            end
            ST_IMM:  state_d = last_imm ? ST_DONE : ST_IMM;
            default: state_d = ST_PFX;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PFX;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the opcode decode when the opcode is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= W8;
            reg_q    <= 4'h0;
            hibyte_q <= 1'b0;
            need_q   <= 4'd1;
        end else if (opc_take) begin
            width_q  <= cls_width;
            reg_q    <= cls_reg;
            hibyte_q <= cls_hibyte;
            need_q   <= cls_nbytes;
        end
    end

    // Count every accepted byte of the instruction
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            len_q <= '0;
        end else if (accept) begin
            len_q <= len_q + LEN_W'(1);
        end
    end

    // Result outputs
    always_comb begin
        out_valid  = (state_q == ST_DONE);
        err        = (state_q == ST_ERR);
        out_reg    = reg_q;
        out_width  = width_q;
        out_hibyte = hibyte_q;
        out_len    = len_q;
    end

endmodule

// File: rtl/movimm_decoder_chk.sv
// Protocol and result-consistency properties for movimm_decoder.
module movimm_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode64,
    input logic        in_ready,
    input logic        out_valid,
    input logic [3:0]  out_reg,
    input logic [1:0]  out_width,
    input logic        out_hibyte,
    input logic [63:0] out_imm,
    input logic [3:0]  out_len,
    input logic        err
);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, err}));

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || err) |-> !in_ready);

    a_r8_zero_ext8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_width == 2'b00) |-> (out_imm[63:8] == 56'h0));

    a_r8_zero_ext32: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_width == 2'b10) |-> (out_imm[63:32] == 32'h0));

    a_r5_hibyte_only8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hibyte) |-> (out_width == 2'b00 && out_reg[3] == 1'b0));

    a_r7_no_ext_in32: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode64) |-> (out_width != 2'b11 && out_reg[3] == 1'b0));

    a_r9_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 4'd2));

endmodule

bind movimm_decoder movimm_decoder_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode64     (mode64),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_reg    (out_reg),
    .out_width  (out_width),
    .out_hibyte (out_hibyte),
    .out_imm    (out_imm),
    .out_len    (out_len),
    .err        (err)
);

// File: tb/movimm_decoder_test.sv
module movimm_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [3:0]  out_reg;
    logic [1:0]  out_width;
    logic        out_hibyte;
    logic [63:0] out_imm;
    logic [3:0]  out_len;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int gap    = 0;

    always #5 clk = ~clk;

    movimm_decoder uut (
        .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_reg(out_reg), .out_width(out_width), .out_hibyte(out_hibyte),
        .out_imm(out_imm), .out_len(out_len), .err(err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [7:0] b);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < gap; i++) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hFF;
    endtask

    task automatic expect_result(input string tag, input logic [3:0] r, input logic [1:0] w,
                                 input logic hi, input logic [63:0] imm, input logic [3:0] len);
        check({tag, " valid"}, out_valid, 1'b1);
        check({tag, " reg"}, out_reg, r);
        check({tag, " width"}, out_width, w);
        check({tag, " hibyte"}, out_hibyte, hi);
        check({tag, " imm"}, out_imm, imm);
        check({tag, " len"}, out_len, len);
        check({tag, " ready low R10"}, in_ready, 1'b0);
        @(negedge clk);
        check({tag, " pulse ends R10"}, out_valid, 1'b0);
        check({tag, " ready back R10"}, in_ready, 1'b1);
    endtask

    task automatic expect_error(input string tag);
        check({tag, " err"}, err, 1'b1);
        check({tag, " no valid"}, out_valid, 1'b0);
        @(negedge clk);
        check({tag, " err pulse R10"}, err, 1'b0);
    endtask

    task automatic t_reset();
        check("R12 out_valid", out_valid, 1'b0);
        check("R12 err", err, 1'b0);
        check("R12 in_ready", in_ready, 1'b1);
    endtask

    task automatic t_byte_loads();
        mode64 = 1'b0;
        send(8'hB3); send(8'h5A);
        expect_result("R1 bl", 4'd3, 2'b00, 1'b0, 64'h5A, 4'd2);
        send(8'hB4); send(8'h7F);
        expect_result("R5 ah", 4'd4, 2'b00, 1'b1, 64'h7F, 4'd2);
        send(8'h66); send(8'hB7); send(8'h01);
        expect_result("R9 66 on byte load", 4'd7, 2'b00, 1'b1, 64'h01, 4'd3);
    endtask

    task automatic t_wide_loads();
        send(8'hB9); send(8'h78); send(8'h56); send(8'h34); send(8'h12);
        expect_result("R2 ecx", 4'd1, 2'b10, 1'b0, 64'h12345678, 4'd5);
        send(8'h66); send(8'hBE); send(8'hCD); send(8'hAB);
        expect_result("R3 si", 4'd6, 2'b01, 1'b0, 64'hABCD, 4'd4);
    endtask

    task automatic t_ext_loads();
        mode64 = 1'b1;
        send(8'h48); send(8'hBF);
        for (int i = 1; i <= 8; i++) send(8'(i));
        expect_result("R4 rdi", 4'd7, 2'b11, 1'b0, 64'h0807060504030201, 4'd10);
        send(8'h66); send(8'h49); send(8'hB8);
        for (int i = 0; i < 8; i++) send(8'hF0 + 8'(i));
        expect_result("R4 W over 66", 4'd8, 2'b11, 1'b0, 64'hF7F6F5F4F3F2F1F0, 4'd11);
        send(8'h40); send(8'hB4); send(8'h11);
        expect_result("R6 spl", 4'd4, 2'b00, 1'b0, 64'h11, 4'd3);
        send(8'h41); send(8'hB5); send(8'h22);
        expect_result("R6 r13b", 4'd13, 2'b00, 1'b0, 64'h22, 4'd3);
        send(8'h41); send(8'hBA); send(8'hEF); send(8'hBE); send(8'hAD); send(8'hDE);
        expect_result("R6 r10d", 4'd10, 2'b10, 1'b0, 64'hDEADBEEF, 4'd6);
        send(8'h66); send(8'h41); send(8'hBB); send(8'h34); send(8'h12);
        expect_result("R9 66 rex 16", 4'd11, 2'b01, 1'b0, 64'h1234, 4'd5);
    endtask

    task automatic t_errors();
        mode64 = 1'b1;
        send(8'h90);
        expect_error("R11 bad opcode");
        send(8'hB0); send(8'h01);
        expect_result("R11 recover", 4'd0, 2'b00, 1'b0, 64'h01, 4'd2);
        send(8'h66); send(8'h66);
        expect_error("R11 dup 66");
        send(8'h48); send(8'h48);
        expect_error("R11 dup rex");
        send(8'h48); send(8'h66);
        expect_error("R11 66 after rex");
        send(8'hB1); send(8'h02);
        expect_result("R11 clean restart", 4'd1, 2'b00, 1'b0, 64'h02, 4'd2);
        mode64 = 1'b0;
        send(8'h48);
        expect_error("R7 rex in 32-bit mode");
    endtask

    task automatic t_bubbles();
        mode64 = 1'b0;
        gap = 2;
        send(8'h66); send(8'hBA); send(8'h3C); send(8'h5D);
        gap = 0;
        expect_result("R13 gaps", 4'd2, 2'b01, 1'b0, 64'h5D3C, 4'd4);
        send(8'hB8); send(8'h04); send(8'h03); send(8'h02); send(8'h01);
        expect_result("R8 order", 4'd0, 2'b10, 1'b0, 64'h01020304, 4'd5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_loads();
        t_wide_loads();
        t_ext_loads();
        t_errors();
        t_bubbles();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule